// File: doc/BRIEF.md
# Multi-Port I/O Select and Interrupt Router

This block is the glue logic of an expansion I/O card that carries three peripheral functions: an auxiliary serial port, a modem serial port and a parallel port. The host bus supplies one decoded select line per port, a three-bit register offset, read and write strobes, and write data. The block routes each access to exactly one enabled port, chosen by a fixed priority, and returns that port's read data. It also merges the ports' interrupt requests onto three host interrupt lines. The merge follows per-port jumper words that are captured while reset is held.

Each port is modelled here by a register stub of eight byte-wide registers, which is enough to observe where every access lands. The auxiliary and parallel stubs each take one interrupt request input. The modem takes three event inputs: receive ready, transmit ready and transmit empty. Each of these has its own enable bit in the modem's jumper word.

Top module: `mpio_router`

## Requirements
- R1: Jumper words are captured only while `rst` is high; changing `cfg_*` inputs after reset changes neither access routing nor interrupt routing.
- R2: Bit 0 of a port's jumper word enables it; the select line of a disabled port is ignored for reads and writes.
- R3: When several enabled ports are selected, the read returns the data of the highest-priority one: auxiliary first, then modem, then parallel.
- R4: A write reaches exactly one port, the highest-priority enabled selected one; the other selected ports keep their contents.
- R5: `rdata` is 0x00 when `rd` is low or when no enabled port is selected.
- R6: Each port decodes all eight offsets 0..7 of `addr` as distinct byte registers.
- R7: Jumper bits 2:1 hold a level code: code 0 raises no interrupt, and codes 1, 2 and 3 drive `host_irq[0]`, `host_irq[1]` and `host_irq[2]` (host lines 3, 4, 5).
- R8: A host line is the OR of the requests of all enabled ports that are assigned its level.
- R9: A request from a disabled port does not affect any host line.
- R10: Modem jumper bits 3, 4 and 5 enable interrupts on receive ready, transmit ready and transmit empty; an event whose bit is clear raises nothing.
- R11: `host_irq` is registered: a request change appears after the next rising clock edge, a dropped request clears its line one edge later, and reset drives all lines low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; jumper words are captured while high |
| cfg_aux | input | 3 | Auxiliary port jumpers: [0] enable, [2:1] level code |
| cfg_modem | input | 6 | Modem jumpers: [0] enable, [2:1] level code, [3] rx-ready, [4] tx-ready, [5] tx-empty interrupt enables |
| cfg_par | input | 3 | Parallel port jumpers: [0] enable, [2:1] level code |
| sel_aux | input | 1 | Decoded select for the auxiliary port |
| sel_modem | input | 1 | Decoded select for the modem port |
| sel_par | input | 1 | Decoded select for the parallel port |
| addr | input | 3 | Register offset within the selected port |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational, zero unless a read hits an enabled port |
| irq_aux | input | 1 | Auxiliary port interrupt request |
| irq_par | input | 1 | Parallel port interrupt request |
| modem_rx_rdy | input | 1 | Modem receive-ready event |
| modem_tx_rdy | input | 1 | Modem transmit-ready event |
| modem_tx_empty | input | 1 | Modem transmit-empty event |
| host_irq | output | 3 | Host interrupt lines 3, 4, 5 as bits 0, 1, 2 |

## Verification
The assertions check on every cycle that no more than one port gets a write strobe, that a disabled port never gets one, that the auxiliary port wins a write when it is selected and enabled, that `rdata` is zero when no read is in progress, that the captured jumpers stay fixed outside reset, and that the host lines are low after reset or after a cycle with no requests. The bench scenarios show what only the data can reveal. They show which port's register holds a written byte, which port a contended read returns, how each level code maps to a host line, the OR of shared levels, the modem event gating, and that jumper changes after reset are ignored.

// File: rtl/mpio_pkg.sv
package mpio_pkg;

    localparam int NPORT       = 3;
    localparam int ADDR_W      = 3;
    localparam int DATA_W      = 8;
    localparam int LVL_W       = 2;
    localparam int NLINE       = 3;
    localparam int NGATE       = 3;
    localparam int BASE_CFG_W  = 1 + LVL_W;
    localparam int MODEM_CFG_W = BASE_CFG_W + NGATE;
    localparam int NREG        = 1 << ADDR_W;

    // Port index doubles as access priority: lower index wins.
    localparam int P_AUX   = 0;
    localparam int P_MODEM = 1;
    localparam int P_PAR   = 2;

    typedef struct packed {
        logic [NGATE-1:0] gate;
        logic [LVL_W-1:0] lvl;
        logic             en;
    } port_cfg_t;

    function automatic port_cfg_t unpack_cfg(input logic [MODEM_CFG_W-1:0] w);
        port_cfg_t c;
        c.en   = w[0];
        c.lvl  = w[LVL_W:1];
        c.gate = w[MODEM_CFG_W-1:BASE_CFG_W];
        return c;
    endfunction

    // Level code k (k>0) drives host line index k-1; code 0 drives nothing.
    function automatic logic [NLINE-1:0] lvl_to_lines(input logic [LVL_W-1:0] lvl);
        logic [NLINE-1:0] l;
        for (int k = 0; k < NLINE; k++) begin
            l[k] = (lvl == LVL_W'(k + 1));
        end
        return l;
    endfunction

endpackage

// File: rtl/mpio_cfg_latch.sv
module mpio_cfg_latch
    import mpio_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  port_cfg_t [NPORT-1:0] cfg_in,
    output port_cfg_t [NPORT-1:0] cfg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= cfg_in;
        end
    end

endmodule

// File: rtl/mpio_select.sv
module mpio_select
    import mpio_pkg::*;
(
    input  logic [NPORT-1:0] sel,
    input  logic [NPORT-1:0] en,
    input  logic             rd,
    input  logic             wr,
    output logic [NPORT-1:0] grant,
    output logic [NPORT-1:0] port_we,
    output logic [NPORT-1:0] port_re
);

    logic [NPORT-1:0] match;

    assign match = sel & en;

    always_comb begin
        logic taken;
        taken = 1'b0;
        for (int i = 0; i < NPORT; i++) begin
            grant[i] = match[i] & ~taken;
            taken    = taken | match[i];
        end
    end

    assign port_we = grant & {NPORT{wr}};
    assign port_re = grant & {NPORT{rd}};

endmodule

// File: rtl/mpio_reg_stub.sv
module mpio_reg_stub
    import mpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) begin
                regs[i] <= '0;
            end
        end else if (we) begin
            regs[addr] <= wdata;
        end
    end

    assign rdata = regs[addr];

endmodule

// File: rtl/mpio_irq_router.sv
module mpio_irq_router
    import mpio_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  port_cfg_t [NPORT-1:0] cfg,
    input  logic [NPORT-1:0]      req_raw,
    input  logic [NGATE-1:0]      modem_evt,
    output logic [NLINE-1:0]      host_irq
);

    logic [NPORT-1:0] req_eff;
    logic [NLINE-1:0] next_lines;

    generate
        for (genvar p = 0; p < NPORT; p++) begin : g_req
            if (p == P_MODEM) begin : g_gated
                assign req_eff[p] = cfg[p].en & |(modem_evt & cfg[p].gate);
            end else begin : g_plain
                assign req_eff[p] = cfg[p].en & req_raw[p];
            end
        end
    endgenerate

    always_comb begin
        next_lines = '0;
        for (int p = 0; p < NPORT; p++) begin
            if (req_eff[p]) begin
                next_lines = next_lines | lvl_to_lines(cfg[p].lvl);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            host_irq <= '0;
        end else begin
            host_irq <= next_lines;
        end
    end

endmodule

// File: rtl/mpio_router.sv
module mpio_router
    import mpio_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic [BASE_CFG_W-1:0]  cfg_aux,
    input  logic [MODEM_CFG_W-1:0] cfg_modem,
    input  logic [BASE_CFG_W-1:0]  cfg_par,
    input  logic                   sel_aux,
    input  logic                   sel_modem,
    input  logic                   sel_par,
    input  logic [ADDR_W-1:0]      addr,
    input  logic                   rd,
    input  logic                   wr,
    input  logic [DATA_W-1:0]      wdata,
    output logic [DATA_W-1:0]      rdata,
    input  logic                   irq_aux,
    input  logic                   irq_par,
    input  logic                   modem_rx_rdy,
    input  logic                   modem_tx_rdy,
    input  logic                   modem_tx_empty,
    output logic [NLINE-1:0]       host_irq
);

    localparam int PAD_W = MODEM_CFG_W - BASE_CFG_W;

    port_cfg_t [NPORT-1:0] cfg_in;
    port_cfg_t [NPORT-1:0] cfg_q;
    logic [NPORT-1:0]      sel_vec;
    logic [NPORT-1:0]      port_en;
    logic [NPORT-1:0]      grant;
    logic [NPORT-1:0]      port_we;
    logic [NPORT-1:0]      port_re;
    logic [DATA_W-1:0]     stub_rdata [NPORT];
    logic [NPORT-1:0]      req_raw;

    always_comb begin
        cfg_in[P_AUX]   = unpack_cfg({{PAD_W{1'b0}}, cfg_aux});
        cfg_in[P_MODEM] = unpack_cfg(cfg_modem);
        cfg_in[P_PAR]   = unpack_cfg({{PAD_W{1'b0}}, cfg_par});
    end

    always_comb begin
        sel_vec          = '0;
        sel_vec[P_AUX]   = sel_aux;
        sel_vec[P_MODEM] = sel_modem;
        sel_vec[P_PAR]   = sel_par;
        req_raw          = '0;
        req_raw[P_AUX]   = irq_aux;
        req_raw[P_PAR]   = irq_par;
    end

    mpio_cfg_latch i_cfg (
        .clk    (clk),
        .rst    (rst),
        .cfg_in (cfg_in),
        .cfg_q  (cfg_q)
    );

    generate
        for (genvar p = 0; p < NPORT; p++) begin : g_en
            assign port_en[p] = cfg_q[p].en;
        end
    endgenerate

    mpio_select i_sel (
        .sel     (sel_vec),
        .en      (port_en),
        .rd      (rd),
        .wr      (wr),
        .grant   (grant),
        .port_we (port_we),
        .port_re (port_re)
    );

    generate
        for (genvar p = 0; p < NPORT; p++) begin : g_stub
            mpio_reg_stub i_stub (
                .clk   (clk),
                .rst   (rst),
                .we    (port_we[p]),
                .addr  (addr),
                .wdata (wdata),
                .rdata (stub_rdata[p])
            );
        end
    endgenerate

    always_comb begin
        rdata = '0;
        for (int p = 0; p < NPORT; p++) begin
            if (port_re[p]) begin
                rdata = rdata | stub_rdata[p];
            end
        end
    end

    mpio_irq_router i_irq (
        .clk       (clk),
        .rst       (rst),
        .cfg       (cfg_q),
        .req_raw   (req_raw),
        .modem_evt ({modem_tx_empty, modem_tx_rdy, modem_rx_rdy}),
        .host_irq  (host_irq)
    );

endmodule

// File: rtl/mpio_router_chk.sv
module mpio_router_chk
    import mpio_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  rd,
    input logic                  wr,
    input logic [NPORT-1:0]      sel_vec,
    input logic [NPORT-1:0]      port_en,
    input logic [NPORT-1:0]      port_we,
    input port_cfg_t [NPORT-1:0] cfg_q,
    input logic [NPORT-1:0]      any_req,
    input logic [DATA_W-1:0]     rdata,
    input logic [NLINE-1:0]      host_irq
);

    // R4: at most one port strobed per write
    a_r4_single_write: assert property (@(posedge clk) disable iff (rst)
        $onehot0(port_we));

    // R2: disabled ports never strobed
    a_r2_disabled_no_write: assert property (@(posedge clk) disable iff (rst)
        (port_we & ~port_en) == '0);

    // R3: auxiliary wins when enabled and selected
    a_r3_aux_priority: assert property (@(posedge clk) disable iff (rst)
        (wr && sel_vec[P_AUX] && port_en[P_AUX]) |-> port_we == NPORT'(1 << P_AUX));

    // R5: no read strobe means zero data
    a_r5_idle_read_zero: assert property (@(posedge clk) disable iff (rst)
        !rd |-> rdata == '0);

    // R1: captured jumpers do not move outside reset
    a_r1_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(cfg_q));

    // R11: reset clears host lines
    a_r11_reset_low: assert property (@(posedge clk)
        rst |=> host_irq == '0);

    // R11: a cycle with no requests leaves all lines low after the edge
    a_r11_quiet_clears: assert property (@(posedge clk) disable iff (rst)
        (any_req == '0) |=> host_irq == '0);

endmodule

bind mpio_router mpio_router_chk i_chk (
    .clk      (clk),
    .rst      (rst),
    .rd       (rd),
    .wr       (wr),
    .sel_vec  (sel_vec),
    .port_en  (port_en),
    .port_we  (port_we),
    .cfg_q    (cfg_q),
    .any_req  ({irq_par, modem_rx_rdy | modem_tx_rdy | modem_tx_empty, irq_aux}),
    .rdata    (rdata),
    .host_irq (host_irq)
);

// File: tb/test_mpio_router.sv
module test_mpio_router;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 100000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] cfg_aux = '0;
    logic [5:0] cfg_modem = '0;
    logic [2:0] cfg_par = '0;
    logic       sel_aux = 0, sel_modem = 0, sel_par = 0;
    logic [2:0] addr = '0;
    logic       rd = 0, wr = 0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq_aux = 0, irq_par = 0;
    logic       modem_rx_rdy = 0, modem_tx_rdy = 0, modem_tx_empty = 0;
    logic [2:0] host_irq;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mpio_router i_mpio_router (
        .clk(clk), .rst(rst),
        .cfg_aux(cfg_aux), .cfg_modem(cfg_modem), .cfg_par(cfg_par),
        .sel_aux(sel_aux), .sel_modem(sel_modem), .sel_par(sel_par),
        .addr(addr), .rd(rd), .wr(wr), .wdata(wdata), .rdata(rdata),
        .irq_aux(irq_aux), .irq_par(irq_par),
        .modem_rx_rdy(modem_rx_rdy), .modem_tx_rdy(modem_tx_rdy),
        .modem_tx_empty(modem_tx_empty), .host_irq(host_irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [2:0] ca, input logic [5:0] cm, input logic [2:0] cp);
        @(negedge clk);
        cfg_aux = ca; cfg_modem = cm; cfg_par = cp;
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic bus_write(input logic [2:0] s, input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        {sel_par, sel_modem, sel_aux} = s;
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        {sel_par, sel_modem, sel_aux} = '0;
        wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] s, input logic [2:0] a, input logic [7:0] exp,
                            input string req);
        @(negedge clk);
        {sel_par, sel_modem, sel_aux} = s;
        addr = a; rd = 1'b1;
        #1;
        check(rdata == exp, req, rdata, exp);
        {sel_par, sel_modem, sel_aux} = '0;
        rd = 1'b0;
    endtask

    // drive requests at negedge, sample host lines at the next negedge
    task automatic irq_step(input logic ia, input logic ip, input logic [2:0] mev,
                            input logic [2:0] exp, input string req);
        @(negedge clk);
        irq_aux = ia; irq_par = ip;
        {modem_tx_empty, modem_tx_rdy, modem_rx_rdy} = mev;
        @(negedge clk);
        check(host_irq == exp, req, host_irq, exp);
    endtask

    task automatic t_reset_state;
        do_reset(3'b011, 6'b000101, 3'b111);
        #1;
        check(host_irq == 3'b000, "R11", host_irq, 0);
        check(rdata == 8'h00, "R5", rdata, 0);
    endtask

    task automatic t_offsets;
        for (int i = 0; i < 8; i++) bus_write(3'b001, 3'(i), 8'(8'h10 + i));
        for (int i = 0; i < 8; i++) bus_read(3'b001, 3'(i), 8'(8'h10 + i), "R6");
        bus_write(3'b010, 3'd3, 8'h5A);
        bus_write(3'b100, 3'd3, 8'hC3);
        bus_read(3'b010, 3'd3, 8'h5A, "R6");
        bus_read(3'b100, 3'd3, 8'hC3, "R6");
    endtask

    task automatic t_priority_read;
        bus_read(3'b111, 3'd3, 8'h13, "R3");
        bus_read(3'b110, 3'd3, 8'h5A, "R3");
        bus_read(3'b101, 3'd3, 8'h13, "R3");
    endtask

    task automatic t_multi_write;
        bus_write(3'b111, 3'd3, 8'hEE);
        bus_read(3'b001, 3'd3, 8'hEE, "R4");
        bus_read(3'b010, 3'd3, 8'h5A, "R4");
        bus_read(3'b100, 3'd3, 8'hC3, "R4");
        bus_write(3'b110, 3'd5, 8'h77);
        bus_read(3'b010, 3'd5, 8'h77, "R4");
        bus_read(3'b100, 3'd5, 8'h00, "R4");
    endtask

    task automatic t_idle_read;
        @(negedge clk);
        {sel_par, sel_modem, sel_aux} = 3'b111; addr = 3'd3; rd = 1'b0;
        #1;
        check(rdata == 8'h00, "R5", rdata, 0);
        {sel_par, sel_modem, sel_aux} = '0;
        bus_read(3'b000, 3'd3, 8'h00, "R5");
    endtask

    task automatic t_levels;
        // aux lvl1, modem lvl2 rx-gate only, par lvl3
        do_reset(3'b011, 6'b001101, 3'b111);
        irq_step(1, 0, 3'b000, 3'b001, "R7");
        irq_step(0, 0, 3'b000, 3'b000, "R11");
        irq_step(0, 1, 3'b000, 3'b100, "R7");
        irq_step(0, 0, 3'b001, 3'b010, "R7");
        irq_step(0, 0, 3'b010, 3'b000, "R10");
        irq_step(0, 0, 3'b100, 3'b000, "R10");
        irq_step(1, 1, 3'b001, 3'b111, "R8");
        irq_step(0, 0, 3'b000, 3'b000, "R11");
    endtask

    task automatic t_disabled_and_shared;
        // aux disabled lvl1, modem lvl1 all gates, par lvl1
        do_reset(3'b010, 6'b111011, 3'b011);
        bus_write(3'b001, 3'd0, 8'h99);
        bus_read(3'b001, 3'd0, 8'h00, "R2");
        bus_read(3'b010, 3'd0, 8'h00, "R2");
        bus_read(3'b100, 3'd0, 8'h00, "R2");
        bus_write(3'b010, 3'd1, 8'h3C);
        bus_read(3'b011, 3'd1, 8'h3C, "R2");
        irq_step(1, 0, 3'b000, 3'b000, "R9");
        irq_step(0, 1, 3'b000, 3'b001, "R8");
        irq_step(0, 1, 3'b100, 3'b001, "R8");
        irq_step(0, 0, 3'b100, 3'b001, "R8");
        irq_step(0, 0, 3'b010, 3'b001, "R10");
        irq_step(0, 0, 3'b000, 3'b000, "R11");
    endtask

    task automatic t_cfg_frozen;
        // aux disabled, par enabled with level 0
        do_reset(3'b010, 6'b000000, 3'b001);
        irq_step(0, 1, 3'b000, 3'b000, "R7");
        bus_write(3'b100, 3'd2, 8'hA5);
        @(negedge clk);
        cfg_aux = 3'b011; cfg_modem = 6'b111011; cfg_par = 3'b011;
        bus_read(3'b001, 3'd2, 8'h00, "R1");
        bus_read(3'b010, 3'd2, 8'h00, "R1");
        bus_read(3'b110, 3'd2, 8'hA5, "R1");
        irq_step(1, 1, 3'b111, 3'b000, "R1");
        irq_step(0, 0, 3'b000, 3'b000, "R1");
    endtask

    initial begin
        t_reset_state;
        t_offsets;
        t_priority_read;
        t_multi_write;
        t_idle_read;
        t_levels;
        t_disabled_and_shared;
        t_cfg_frozen;
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule